// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the protocol side of a byte-wide serial EEPROM that answers on a two-wire bus. It watches the clock and data lines through synchronisers and a majority filter, recognises bus Start and Stop conditions, and shifts bytes in and out. The first byte of every transfer is a control byte that carries a device code, a block-select field and a read/write flag. A 9-bit address pointer survives from one transfer to the next.

Write transfers set the pointer and then pass each data byte, with its target address, to a separate page-write engine. The slave raises a one-cycle commit pulse when the Stop arrives. While that engine reports busy, the slave stays silent on the bus, so a master can poll for the end of the write cycle. Read transfers send bytes from the memory array, most significant bit first. A read can start at the current pointer, or at a pointer just loaded by a write that is cut short with a repeated Start. Reads continue for as long as the master acknowledges.

The SDA output is an active-high pull-low enable. The memory is read through a combinational address/data pair.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A falling data line while the filtered clock is high is a Start, and it restarts control-byte reception from any state. A rising data line while the clock is high is a Stop; it returns the block to idle and releases SDA. SDA is released after reset.
- R2: Bits 7..4 of the control byte (received first, MSB first) must equal 1010 for an acknowledge. Bits 3..2 are ignored, bit 1 is pointer bit 8, and bit 0 selects read (1) or write (0). A mismatch gets no acknowledge, and every byte up to the next Start or Stop is ignored.
- R3: An accepted byte is acknowledged by pulling SDA from the clock fall after its eighth bit until the next clock fall. The slave never pulls SDA while the master drives a bit.
- R4: While `engine_busy` is high, no byte is acknowledged, including the control byte, and nothing is staged.
- R5: In a write, the byte after the control byte sets the pointer to {block bit, byte}. Each acknowledged data byte then appears on `stage_we`/`stage_addr`/`stage_data` for one cycle, addressed at the current pointer.
- R6: After each staged byte only the low four pointer bits advance, wrapping within the 16-byte page, so a seventeenth byte lands on the first byte's address.
- R7: `commit` pulses for one cycle after a Stop that ends a write with at least one staged byte. A repeated Start produces no commit but keeps the new pointer, and a write with no data byte commits nothing.
- R8: Read bytes leave MSB first. Each bit is presented after a clock fall and held through the next clock high.
- R9: Once a read byte has been sent, the full 9-bit pointer increments and wraps from 1FFh to 000h. A master acknowledge brings the next byte; a master no-acknowledge releases SDA until the next Start or Stop.
- R10: A read control byte reads from the current pointer, with bit 8 replaced by the control byte's block bit.
- R11: SDA pull changes only while the filtered clock is low, except for the release on Start or Stop.
- R12: A Start or Stop in the middle of a byte discards that byte. The bytes staged before it are still committed by a Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | High pulls the data line low |
| mem_rd_addr | output | 9 | Array read address (current pointer) |
| mem_rd_data | input | 8 | Array read data for `mem_rd_addr` |
| stage_we | output | 1 | One-cycle strobe handing a data byte to the write engine |
| stage_addr | output | 9 | Target address of the staged byte |
| stage_data | output | 8 | Staged byte |
| commit | output | 1 | One-cycle pulse telling the write engine to program |
| engine_busy | input | 1 | Write engine is programming; the slave must stay silent |

## Verification
A bus condition and byte shifting can land in the same cycle: a Stop or repeated Start that arrives a few bits into a byte is seen while the bit counter and shift register are part-way through. The bench provokes this by cutting write and address bytes after three or four bits. It judges the outcome through the exact sequence of staged bytes, the commit count, and the data that a later read returns. The second overlap is the acknowledge decision and the write engine's busy flag: control bytes are sent immediately after a commit and again once busy clears, and the data line is compared with the model on every clock of each acknowledge slot.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_WDAT,
      ST_RDAT,
      ST_SKIP
   } twi_st_e;

   // population count used by the majority vote
   function automatic int ones_in(input logic [31:0] v, input int n);
      int c;
      c = 0;
      for (int i = 0; i < n; i++) c += int'(v[i]);
      return c;
   endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   import twi_eeprom_pkg::*;

   localparam int SMSB = SYNC_STAGES - 1;

   logic [SMSB:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SMSB-1:0], din};
   end

   generate
      if (FILT_TAPS == 1) begin : g_bypass
         assign dout = sync_q[SMSB];
      end else begin : g_vote
         localparam int TMSB = FILT_TAPS - 1;
         logic [TMSB:0] taps;
         logic          vote_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               taps   <= '1;
               vote_q <= 1'b1;
            end else begin
               taps   <= {taps[TMSB-1:0], sync_q[SMSB]};
               vote_q <= (ones_in(32'(taps), FILT_TAPS) > (FILT_TAPS / 2));
            end
         end
         assign dout = vote_q;
      end
   endgenerate

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_lvl,
   input  logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_lvl;
         sda_p <= sda_lvl;
      end
   end

   assign scl_rise = scl_lvl & ~scl_p;
   assign scl_fall = ~scl_lvl & scl_p;
   assign start_ev = scl_lvl & scl_p & sda_p & ~sda_lvl;
   assign stop_ev  = scl_lvl & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
   parameter int          SYNC_STAGES = 2,
   parameter int          FILT_TAPS   = 3,
   parameter int          PAGE_BYTES  = 16,
   parameter int          BLK_BITS    = 1,
   parameter logic [3:0]  CTRL_CODE   = 4'b1010,
   localparam int         AW          = 8 + BLK_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_in,
   input  logic          sda_in,
   output logic          sda_pull,
   output logic [AW-1:0] mem_rd_addr,
   input  logic [7:0]    mem_rd_data,
   output logic          stage_we,
   output logic [AW-1:0] stage_addr,
   output logic [7:0]    stage_data,
   output logic          commit,
   input  logic          engine_busy
);
   import twi_eeprom_pkg::*;

   localparam int         PG_BITS  = $clog2(PAGE_BYTES);
   localparam logic [3:0] LAST_BIT = 4'd8;

   generate
      if (FILT_TAPS < 1 || (FILT_TAPS % 2) == 0) begin : g_bad_taps
         $error("FILT_TAPS must be odd and positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PAGE_BYTES < 2 || PAGE_BYTES > 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two from 2 to 256");
      end
      if (BLK_BITS < 1 || BLK_BITS > 3) begin : g_bad_blk
         $error("BLK_BITS must be 1 to 3");
      end
   endgenerate

   // ---------------- line conditioning ----------------
   logic [1:0] raw_lines, filt_lines;
   assign raw_lines = {scl_in, sda_in};

   generate
      for (genvar i = 0; i < 2; i++) begin : g_line
         twi_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_TAPS  (FILT_TAPS)
         ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[i]),
            .dout (filt_lines[i])
         );
      end
   endgenerate

   logic scl_f, sda_f;
   assign scl_f = filt_lines[1];
   assign sda_f = filt_lines[0];

   logic scl_rise, scl_fall, start_ev, stop_ev;

   twi_bus_events u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_lvl (scl_f),
      .sda_lvl (sda_f),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev)
   );

   // ---------------- byte engine ----------------
   twi_st_e              st;
   logic [3:0]           bitc;
   logic [7:0]           sh;
   logic                 ackph;
   logic                 rw;
   logic                 mack;
   logic                 staged;
   logic [BLK_BITS-1:0]  blk;
   logic [AW-1:0]        ptr;
   logic                 pull;
   logic                 take;
   logic                 rx_state;

   assign rx_state    = (st == ST_CTRL) || (st == ST_ADDR) || (st == ST_WDAT);
   assign take        = !engine_busy && ((st != ST_CTRL) || (sh[7:4] == CTRL_CODE));
   assign mem_rd_addr = ptr;
   assign sda_pull    = pull;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         bitc       <= '0;
         sh         <= '0;
         ackph      <= 1'b0;
         rw         <= 1'b0;
         mack       <= 1'b0;
         staged     <= 1'b0;
         blk        <= '0;
         ptr        <= '0;
         pull       <= 1'b0;
         stage_we   <= 1'b0;
         stage_addr <= '0;
         stage_data <= '0;
         commit     <= 1'b0;
      end else begin
         stage_we <= 1'b0;
         commit   <= 1'b0;
         if (stop_ev) begin
            commit <= (st == ST_WDAT) && staged;
            st     <= ST_IDLE;
            pull   <= 1'b0;
            ackph  <= 1'b0;
            bitc   <= '0;
            staged <= 1'b0;
         end else if (start_ev) begin
            st     <= ST_CTRL;
            pull   <= 1'b0;
            ackph  <= 1'b0;
            bitc   <= '0;
            staged <= 1'b0;
         end else if (rx_state) begin
            if (scl_rise && !ackph && bitc < LAST_BIT) begin
               sh   <= {sh[6:0], sda_f};
               bitc <= bitc + 4'd1;
            end
            if (scl_fall) begin
               if (ackph) begin
                  ackph <= 1'b0;
                  pull  <= 1'b0;
                  bitc  <= '0;
                  if (st == ST_CTRL) begin
                     if (rw) begin
                        st   <= ST_RDAT;
                        sh   <= mem_rd_data;
                        pull <= ~mem_rd_data[7];
                     end else begin
                        st <= ST_ADDR;
                     end
                  end else begin
                     st <= ST_WDAT;
                  end
               end else if (bitc == LAST_BIT) begin
                  if (take) begin
                     ackph <= 1'b1;
                     pull  <= 1'b1;
                     case (st)
                        ST_CTRL: begin
                           blk <= sh[BLK_BITS:1];
                           rw  <= sh[0];
                           if (sh[0]) ptr[AW-1:8] <= sh[BLK_BITS:1];
                        end
                        ST_ADDR: ptr <= {blk, sh};
                        default: begin
                           stage_we   <= 1'b1;
                           stage_addr <= ptr;
                           stage_data <= sh;
                           staged     <= 1'b1;
                           ptr[PG_BITS-1:0] <= ptr[PG_BITS-1:0] + 1'b1;
                        end
                     endcase
                  end else begin
                     st <= ST_SKIP;
                  end
               end
            end
         end else if (st == ST_RDAT) begin
            if (scl_rise) begin
               if (ackph) mack <= ~sda_f;
               else       bitc <= bitc + 4'd1;
            end
            if (scl_fall) begin
               if (!ackph) begin
                  if (bitc == LAST_BIT) begin
                     pull  <= 1'b0;
                     ackph <= 1'b1;
                     ptr   <= ptr + 1'b1;
                  end else begin
                     sh   <= {sh[6:0], 1'b0};
                     pull <= ~sh[6];
                  end
               end else begin
                  ackph <= 1'b0;
                  bitc  <= '0;
                  if (mack) begin
                     sh   <= mem_rd_data;
                     pull <= ~mem_rd_data[7];
                  end else begin
                     st   <= ST_SKIP;
                     pull <= 1'b0;
                  end
               end
            end
         end
      end
   end

   // ---------------- assertions ----------------
   a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev && !stop_ev) |=> (st == ST_CTRL && bitc == 4'd0 && !sda_pull));

   a_r2_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CTRL && scl_fall && !ackph && bitc == LAST_BIT && sh[7:4] != CTRL_CODE
       && !stop_ev && !start_ev) |=> (st == ST_SKIP && !sda_pull));

   a_r4_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (engine_busy && rx_state && scl_fall && !ackph && bitc == LAST_BIT
       && !stop_ev && !start_ev) |=> (!sda_pull && !stage_we));

   a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      stage_we |-> (stage_addr[AW-1:PG_BITS] == ptr[AW-1:PG_BITS] &&
                    ptr[PG_BITS-1:0] == PG_BITS'(stage_addr[PG_BITS-1:0] + 1'b1)));

   a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(stop_ev));

   a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> (!$past(scl_f) || $past(stop_ev) || $past(start_ev)));

endmodule

// File: tb/sim_twi_eeprom_slave.sv
`timescale 1ns/1ps
module sim_twi_eeprom_slave;
   localparam int H        = 16;
   localparam int BUSY_CYC = 1500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_pull;
   wire  sda_line = sda_m & ~sda_pull;

   logic [8:0] rd_addr;
   logic [7:0] rd_data;
   logic       stage_we, commit, engine_busy;
   logic [8:0] stage_addr;
   logic [7:0] stage_data;

   logic [7:0] mem_m  [512];
   logic [7:0] pend_d [512];
   bit         pend_v [512];
   int         busy_cnt = 0;
   int         commits_seen = 0;
   int         total_cnt = 0;
   int         bad_cnt = 0;
   logic [16:0] exp_q[$];
   logic [8:0] ptr_m = '0;

   assign rd_data     = mem_m[rd_addr];
   assign engine_busy = (busy_cnt != 0);

   twi_eeprom_slave u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_in     (scl_m),
      .sda_in     (sda_line),
      .sda_pull   (sda_pull),
      .mem_rd_addr(rd_addr),
      .mem_rd_data(rd_data),
      .stage_we   (stage_we),
      .stage_addr (stage_addr),
      .stage_data (stage_data),
      .commit     (commit),
      .engine_busy(engine_busy)
   );

   function automatic logic [7:0] init_val(input int a);
      return 8'((a * 37 + 5) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total_cnt++;
      if (!ok) begin
         bad_cnt++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural write engine and stage monitor
   always @(negedge clk) begin
      logic [16:0] e;
      if (rst_n && stage_we) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected stage", int'({stage_addr, stage_data}), 0);
         end else begin
            e = exp_q.pop_front();
            chk({stage_addr, stage_data} == e, "R5/R6 staged byte",
                int'({stage_addr, stage_data}), int'(e));
         end
         pend_d[stage_addr] = stage_data;
         pend_v[stage_addr] = 1'b1;
      end
      if (rst_n && commit) begin
         commits_seen++;
         for (int a = 0; a < 512; a++) begin
            if (pend_v[a]) mem_m[a] = pend_d[a];
            pend_v[a] = 1'b0;
         end
         busy_cnt = BUSY_CYC;
      end else if (busy_cnt > 0) begin
         busy_cnt--;
      end
   end

   task automatic half();
      repeat (H) @(posedge clk);
      #1;
   endtask

   task automatic gap();
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic put_bit(input logic b, input string req);
      gap();
      sda_m = b;
      half();
      scl_m = 1'b1;
      for (int k = 0; k < H; k++) begin
         @(negedge clk);
         chk(sda_line === b, req, int'(sda_line), int'(b));
      end
      @(posedge clk); #1;
      scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string req);
      for (int i = 7; i >= 0; i--) put_bit(d[i], "R3 no pull during master bit");
      gap();
      sda_m = 1'b1;
      half();
      scl_m = 1'b1;
      for (int k = 0; k < H; k++) begin
         @(negedge clk);
         chk(sda_line === !exp_ack, req, int'(sda_line), int'(!exp_ack));
      end
      @(posedge clk); #1;
      scl_m = 1'b0;
   endtask

   task automatic recv_byte(input logic [7:0] e, input bit mack, input string req);
      for (int i = 7; i >= 0; i--) begin
         gap();
         sda_m = 1'b1;
         half();
         scl_m = 1'b1;
         for (int k = 0; k < H; k++) begin
            @(negedge clk);
            chk(sda_line === e[i], req, int'(sda_line), int'(e[i]));
         end
         @(posedge clk); #1;
         scl_m = 1'b0;
      end
      gap();
      sda_m = !mack;
      half();
      scl_m = 1'b1;
      half();
      scl_m = 1'b0;
      ptr_m = ptr_m + 9'd1;
   endtask

   task automatic bus_start();
      gap();
      sda_m = 1'b1;
      half();
      scl_m = 1'b1;
      half();
      sda_m = 1'b0;
      half();
      scl_m = 1'b0;
      for (int a = 0; a < 512; a++) pend_v[a] = 1'b0;
   endtask

   task automatic bus_stop();
      gap();
      sda_m = 1'b0;
      half();
      scl_m = 1'b1;
      half();
      sda_m = 1'b1;
      half();
      half();
   endtask

   task automatic wdata(input logic [7:0] d);
      exp_q.push_back({ptr_m, d});
      send_byte(d, 1'b1, "R5 data ack");
      ptr_m[3:0] = ptr_m[3:0] + 4'd1;
   endtask

   task automatic set_ptr(input logic b, input logic [7:0] a);
      bus_start();
      send_byte({4'hA, 2'b00, b, 1'b0}, 1'b1, "R2 write control ack");
      send_byte(a, 1'b1, "R5 address ack");
      ptr_m = {b, a};
   endtask

   task automatic rd_ctrl(input logic b);
      bus_start();
      send_byte({4'hA, 2'b00, b, 1'b1}, 1'b1, "R2 read control ack");
      ptr_m[8] = b;
   endtask

   task automatic chk_commits(input int e, input string req);
      repeat (4) @(negedge clk);
      chk(commits_seen == e, req, commits_seen, e);
   endtask

   task automatic wait_idle();
      while (engine_busy) @(posedge clk);
      half();
   endtask

   initial begin
      repeat (3000000) @(posedge clk);
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad_cnt++;
      total_cnt++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
      $finish;
   end

   initial begin : main
      int ncommit;
      for (int a = 0; a < 512; a++) begin
         mem_m[a]  = init_val(a);
         pend_v[a] = 1'b0;
      end
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(sda_pull == 1'b0, "R1 reset pull", int'(sda_pull), 0);
      chk(stage_we == 1'b0, "R1 reset stage", int'(stage_we), 0);
      chk(commit == 1'b0, "R1 reset commit", int'(commit), 0);
      ncommit = 0;

      // byte write of 3C at 005
      set_ptr(1'b0, 8'h05);
      wdata(8'h3C);
      bus_stop();
      ncommit++;
      chk_commits(ncommit, "R7 commit after byte write");

      // R4 acknowledge polling while busy
      chk(engine_busy == 1'b1, "R4 engine busy", int'(engine_busy), 1);
      bus_start();
      send_byte(8'hA0, 1'b0, "R4 control ignored while busy");
      bus_stop();
      chk_commits(ncommit, "R7 no commit for polling");
      wait_idle();
      bus_start();
      send_byte(8'hA0, 1'b1, "R4 control acked once idle");
      bus_stop();
      chk_commits(ncommit, "R7 no commit without data");

      // random read 005 -> 3C
      set_ptr(1'b0, 8'h05);
      rd_ctrl(1'b0);
      recv_byte(8'h3C, 1'b0, "R8 random read data");
      bus_stop();

      // page write in block 1 starting at 11E, 18 bytes
      set_ptr(1'b1, 8'h1E);
      for (int k = 0; k < 18; k++) wdata(8'(8'h80 + k));
      chk(ptr_m == 9'h110, "R6 model pointer", int'(ptr_m), 9'h110);
      bus_stop();
      ncommit++;
      chk_commits(ncommit, "R7 commit after page write");
      wait_idle();

      // sequential read back of the page
      set_ptr(1'b1, 8'h10);
      rd_ctrl(1'b1);
      for (int j = 0; j < 16; j++) begin
         logic [7:0] ev;
         ev = (j < 14) ? 8'(8'h82 + j) : ((j == 14) ? 8'h90 : 8'h91);
         recv_byte(ev, (j != 15), "R6 page overlay read");
      end
      bus_stop();

      // R9 sequential read across 1FF -> 000
      set_ptr(1'b1, 8'hFE);
      rd_ctrl(1'b1);
      recv_byte(init_val(9'h1FE), 1'b1, "R9 read 1FE");
      recv_byte(init_val(9'h1FF), 1'b1, "R9 read 1FF");
      recv_byte(init_val(9'h000), 1'b1, "R9 wrap to 000");
      recv_byte(init_val(9'h001), 1'b0, "R9 read 001");
      bus_stop();

      // R10 current-address reads
      chk(ptr_m == 9'h002, "R10 model pointer", int'(ptr_m), 2);
      rd_ctrl(1'b0);
      recv_byte(init_val(9'h002), 1'b0, "R10 current read block0");
      bus_stop();
      rd_ctrl(1'b1);
      recv_byte(init_val(9'h103), 1'b0, "R10 current read block1");
      bus_stop();

      // R2 bad device code: silent until Stop
      bus_start();
      send_byte(8'hB0, 1'b0, "R2 bad code no ack");
      send_byte(8'h12, 1'b0, "R2 ignored byte");
      send_byte(8'h34, 1'b0, "R2 ignored byte");
      bus_stop();
      chk_commits(ncommit, "R2 no commit after bad code");

      // R2 don't-care bits, R12 Stop mid-byte
      bus_start();
      send_byte(8'hAC, 1'b1, "R2 don't-care bits accepted");
      send_byte(8'h40, 1'b1, "R5 address ack");
      ptr_m = 9'h040;
      wdata(8'h11);
      for (int i = 0; i < 4; i++) put_bit(1'b1, "R3 no pull during partial byte");
      bus_stop();
      ncommit++;
      chk_commits(ncommit, "R12 commit of bytes before cut");
      chk(exp_q.size() == 0, "R12 cut byte not staged", exp_q.size(), 0);
      wait_idle();
      set_ptr(1'b0, 8'h40);
      rd_ctrl(1'b0);
      recv_byte(8'h11, 1'b1, "R12 committed byte read");
      recv_byte(init_val(9'h041), 1'b0, "R12 next byte untouched");
      bus_stop();

      // R7 repeated Start keeps pointer, commits nothing
      set_ptr(1'b0, 8'h50);
      wdata(8'h77);
      rd_ctrl(1'b0);
      recv_byte(init_val(9'h051), 1'b0, "R7 pointer kept after repeated start");
      bus_stop();
      chk_commits(ncommit, "R7 no commit on repeated start");
      set_ptr(1'b0, 8'h50);
      rd_ctrl(1'b0);
      recv_byte(init_val(9'h050), 1'b0, "R7 uncommitted byte absent");
      bus_stop();

      // R12 Start in the middle of the address byte
      bus_start();
      send_byte(8'hA0, 1'b1, "R2 write control ack");
      for (int i = 0; i < 3; i++) put_bit(1'b0, "R3 no pull during partial byte");
      rd_ctrl(1'b0);
      recv_byte(init_val(int'(ptr_m)), 1'b0, "R12 pointer unchanged by cut address");
      bus_stop();
      chk_commits(ncommit, "R12 no commit after cut address");
      chk(exp_q.size() == 0, "R5 all staged bytes seen", exp_q.size(), 0);

      $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
      $finish;
   end
endmodule